// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns the core clock into the bit-rate timing a UART needs. A power-of-two prescaler (1 to 128) feeds a fractional stage. That stage divides by (64 + FD)/64 in steps of 1/64, where FD is a 6-bit setting. A fixed divide-by-32 follows it. The resulting bit period averages 2^DIV·(64 + FD)/2 core cycles, so rates that no integer divider can reach become available. Two FD settings cover most needs: FD = 0x12 for the 9600/19200/38400 family and FD = 0x2D for the 115200 family. With control values 0x80 to 0x85, these give errors well inside one percent.

Every output is a single-cycle clock-enable pulse in the core clock domain. The transmit enable fires once per bit. The receive enable fires sixteen times per bit, for oversampling. When the generator is disabled, both outputs pass through the legacy timer ticks unchanged.

Software programs the block through a write-only register port. Address 0 is the control register and address 1 is the fractional register. Any register write, or a clear enable bit, restarts the timing from zero, so a new rate starts cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the generator is disabled, with DIV = 0 and FD = 0, so txTick equals legacyTxTick and rxTick equals legacyRxTick.
- R2: While the enable bit is 0, txTick equals legacyTxTick and rxTick equals legacyRxTick in the same cycle, combinationally. Writing the fractional register while disabled does not change this.
- R3: While the enable bit is 1, the legacy tick inputs have no effect on txTick or rxTick.
- R4: A write to address 0 sets the enable from data bit 7 and DIV from data bits 2..0. Data bits 6..3 are ignored.
- R5: A write to address 1 sets FD from data bits 5..0. Data bits 7..6 are ignored.
- R6: Let E be the clock edge that takes the last register write, with the block enabled afterwards. Let P = 2^DIV and L = 64 + FD. Counting the cycle after E as cycle 0, bit tick k (k ≥ 1) is high exactly in cycle P·ceil(k·L/2) − 1, and txTick is low in every other cycle. No error builds up over any number of bits.
- R7: Under the same conditions, receive tick j (j ≥ 1) is high exactly in cycle P·ceil(j·L/32) − 1. There are therefore 16 receive ticks per bit, and every bit tick coincides with a receive tick.
- R8: A write to either register while running restarts the prescaler, the fractional accumulator and the divide-by-32 counter, and timing then follows R6/R7 from that write.
- R9: Clearing the enable bit clears the timing state. Setting it again restarts timing exactly as in R6/R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects control, 1 selects fractional register |
| regWrData | input | 8 | Write data |
| legacyTxTick | input | 1 | Transmit enable from the legacy timer path |
| legacyRxTick | input | 1 | Receive enable from the legacy timer path |
| txTick | output | 1 | One pulse per bit when enabled, otherwise legacy transmit tick |
| rxTick | output | 1 | Sixteen pulses per bit when enabled, otherwise legacy receive tick |

## Verification
A corrupt accumulator remainder or a wrong subtract moves a tick by at least one prescaled step. The per-cycle comparison against the closed-form tick positions catches this at the first receive tick after the fault, within 2^DIV·L/32 cycles. A divide-by-32 counter that is off by one shifts the transmit pulse within one bit period. Because every tick position is computed from the write edge, slow drift would also show as a growing offset by the last bit of each window. A failure to restart on a write or on disable shows as a misplaced first tick right after that write.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clear;     // zero the fractional accumulator and bit counter
    logic presTick;  // one prescaled step
  } dpCtl_t;

endpackage

// File: rtl/frac_baud_ctrl.sv
module frac_baud_ctrl
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int FD_W   = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              enable,
  output logic [FD_W-1:0]   fdVal,
  output dpCtl_t            dpCtl
);

  localparam int   PRE_W    = (1 << DIV_W) - 1;
  localparam int   EN_BIT   = DATA_W - 1;
  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_FD  = 1'b1;

  logic [DIV_W-1:0] divSel;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMax;
  logic             ctlWr;
  logic             fdWr;
  logic             clearNow;
  logic             presTick;

  assign ctlWr = regWrEn && (regAddr == ADDR_CTL);
  assign fdWr  = regWrEn && (regAddr == ADDR_FD);

  // Control register: enable and binary divider select; middle bits dropped.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      divSel <= '0;
    end else if (ctlWr) begin
      enable <= regWrData[EN_BIT];
      divSel <= regWrData[DIV_W-1:0];
    end
  end

  // Fractional register: low FD_W bits only.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fdVal <= '0;
    end else if (fdWr) begin
      fdVal <= regWrData[FD_W-1:0];
    end
  end

  // Terminal count of the prescaler is a thermometer mask of 2^DIV - 1.
  for (genvar b = 0; b < PRE_W; b++) begin : g_preMask
    assign preMax[b] = (b < int'(divSel));
  end

  assign clearNow = regWrEn || !enable;
  assign presTick = enable && (preCnt == preMax);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (clearNow || presTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign dpCtl.clear    = clearNow;
  assign dpCtl.presTick = presTick;

  // R6
  pres_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (presTick && !clearNow && (preMax != '0)) |=> !presTick);

  // R9
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |-> (preCnt == '0));

endmodule

// File: rtl/frac_baud_dp.sv
module frac_baud_dp
  import frac_baud_pkg::*;
#(
  parameter int FD_W     = 6,
  parameter int BIT_LOG2 = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtl_t          dpCtl,
  input  logic [FD_W-1:0] fdVal,
  output logic            overTick,
  output logic            bitTick
);

  localparam int ACC_W = FD_W + 1;
  localparam int SUM_W = FD_W + 2;
  localparam int STEP  = 1 << FD_W;

  logic [ACC_W-1:0]    acc;
  logic [SUM_W-1:0]    sumVal;
  logic [SUM_W-1:0]    limitVal;
  logic                fracPulse;
  logic [BIT_LOG2-1:0] bitCnt;

  assign sumVal    = {1'b0, acc} + SUM_W'(STEP);
  assign limitVal  = SUM_W'(STEP) + {2'b00, fdVal};
  assign fracPulse = dpCtl.presTick && (sumVal >= limitVal);

  // Phase accumulator: add one whole step per prescaled tick, keep remainder.
  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.clear) begin
      acc <= '0;
    end else if (dpCtl.presTick) begin
      acc <= fracPulse ? ACC_W'(sumVal - limitVal) : ACC_W'(sumVal);
    end
  end

  // Divide the fractional pulses down to one per bit.
  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.clear) begin
      bitCnt <= '0;
    end else if (fracPulse) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign overTick = fracPulse && bitCnt[0];
  assign bitTick  = fracPulse && (&bitCnt);

  // R6
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, acc} < limitVal));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.clear |=> (!bitTick && !overTick));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int DIV_W    = 3,
  parameter int FD_W     = 6,
  parameter int DATA_W   = 8,
  parameter int BIT_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              legacyTxTick,
  input  logic              legacyRxTick,
  output logic              txTick,
  output logic              rxTick
);

  logic            enable;
  logic [FD_W-1:0] fdVal;
  dpCtl_t          dpCtl;
  logic            overTick;
  logic            bitTick;

  frac_baud_ctrl #(
    .DIV_W (DIV_W),
    .FD_W  (FD_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .enable   (enable),
    .fdVal    (fdVal),
    .dpCtl    (dpCtl)
  );

  frac_baud_dp #(
    .FD_W    (FD_W),
    .BIT_LOG2(BIT_LOG2)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .fdVal   (fdVal),
    .overTick(overTick),
    .bitTick (bitTick)
  );

  // Fallback selection on the enables themselves.
  assign txTick = enable ? bitTick  : legacyTxTick;
  assign rxTick = enable ? overTick : legacyRxTick;

  // R7
  over_at_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txTick) |-> rxTick);

endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;

  localparam int CLK_NS  = 8;
  localparam int WD_CYC  = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       legacyTxTick = 1'b0;
  logic       legacyRxTick = 1'b0;
  logic       txTick;
  logic       rxTick;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .legacyTxTick(legacyTxTick),
    .legacyRxTick(legacyRxTick),
    .txTick      (txTick),
    .rxTick      (rxTick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive a write; returns right after the edge that takes it.
  task automatic writeReg(input logic addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn   = 1'b1;
    regAddr   = addr;
    regWrData = data;
    @(posedge clk);
  endtask

  task automatic writeRegDone(input logic addr, input logic [7:0] data);
    writeReg(addr, data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Outputs must mirror the legacy inputs for n cycles.
  task automatic followLegacy(input int n, input string req);
    int bad = 0;
    int badAct = 0;
    int badExp = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      regWrEn      = 1'b0;
      legacyTxTick = i[0];
      legacyRxTick = i[1];
      #1;
      if ({txTick, rxTick} !== {legacyTxTick, legacyRxTick}) begin
        if (bad == 0) begin
          badAct = {txTick, rxTick};
          badExp = {legacyTxTick, legacyRxTick};
        end
        bad++;
      end
    end
    check(bad == 0, req, "outputs follow legacy {tx,rx}", badAct, badExp);
  endtask

  // Called right after the edge of the write that starts timing.
  task automatic measure(input int div, input int fd, input int nBits,
                         input string reqBit, input string reqOver);
    int len   = 64 + fd;
    int pre   = 1 << div;
    int k     = 1;
    int j     = 1;
    int tBit  = pre * ((len + 1) / 2) - 1;
    int tOver = pre * ((len + 31) / 32) - 1;
    int last  = pre * ((nBits * len + 1) / 2) - 1;
    int bErr  = 0;
    int oErr  = 0;
    int bAt   = -1;
    int oAt   = -1;
    int nBit  = 0;
    int nOver = 0;
    bit expB;
    bit expO;
    for (int i = 0; i <= last; i++) begin
      @(negedge clk);
      regWrEn      = 1'b0;
      legacyTxTick = i[0];     // R3: toggling legacy inputs must not leak
      legacyRxTick = ~i[0];
      #1;
      expB = (i == tBit);
      expO = (i == tOver);
      if (txTick !== expB) begin
        if (bErr == 0) bAt = i;
        bErr++;
      end
      if (rxTick !== expO) begin
        if (oErr == 0) oAt = i;
        oErr++;
      end
      if (expB) begin
        nBit++;
        k++;
        tBit = pre * ((k * len + 1) / 2) - 1;
      end
      if (expO) begin
        nOver++;
        j++;
        tOver = pre * ((j * len + 31) / 32) - 1;
      end
    end
    check(bErr == 0, reqBit,
          $sformatf("bit tick positions DIV=%0d FD=%0d (first bad cycle, mismatches)", div, fd),
          bAt, -1);
    check(oErr == 0, reqOver,
          $sformatf("16x tick positions DIV=%0d FD=%0d (first bad cycle)", div, fd),
          oAt, -1);
    check(nOver == 16 * nBit, reqOver, "16x ticks per bit window", nOver, 16 * nBit);
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYC, WD_CYC);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin : main
    int fdSet [5] = '{0, 1, 18, 45, 63};

    // R1: held in reset, disabled, legacy pass-through
    repeat (4) @(posedge clk);
    @(negedge clk);
    legacyTxTick = 1'b1;
    legacyRxTick = 1'b0;
    #1;
    check(txTick === 1'b1 && rxTick === 1'b0, "R1", "reset tx/rx pass-through",
          {txTick, rxTick}, 2);
    @(negedge clk);
    rstN = 1'b1;
    legacyTxTick = 1'b0;
    legacyRxTick = 1'b1;
    #1;
    check(txTick === 1'b0 && rxTick === 1'b1, "R1", "after reset tx/rx pass-through",
          {txTick, rxTick}, 1);
    followLegacy(20, "R1");

    // R2: FD write while disabled keeps pass-through
    writeRegDone(1'b1, 8'h2D);
    followLegacy(64, "R2");

    // R6 R7 R3: sweep of small dividers over several fractions
    for (int d = 0; d < 4; d++) begin
      for (int f = 0; f < 5; f++) begin
        writeRegDone(1'b1, 8'(fdSet[f]));
        writeReg(1'b0, 8'h80 | 8'(d));
        measure(d, fdSet[f], 16, "R6 R3", "R7 R3");
      end
    end

    // R6 R7: large dividers, few bits
    for (int d = 4; d < 8; d++) begin
      writeRegDone(1'b1, 8'h12);
      writeReg(1'b0, 8'h80 | 8'(d));
      measure(d, 18, 3, "R6", "R7");
    end

    // R4: bits 6..3 set in control are ignored (0xF9 -> enabled, DIV=1)
    writeRegDone(1'b1, 8'h12);
    writeReg(1'b0, 8'hF9);
    measure(1, 18, 8, "R4", "R4");

    // R5: FD bits 7..6 ignored (0xED -> FD=45); R8 restart on FD write
    writeRegDone(1'b0, 8'h82);
    repeat (37) @(posedge clk);
    writeReg(1'b1, 8'hED);
    measure(2, 45, 8, "R5 R8", "R5 R8");

    // R8: mid-stream rewrite of the fractional register
    repeat (53) @(posedge clk);
    writeReg(1'b1, 8'h12);
    measure(2, 18, 8, "R8", "R8");

    // R9: disable falls back to legacy, re-enable restarts timing
    writeRegDone(1'b0, 8'h03);
    followLegacy(100, "R9");
    writeReg(1'b0, 8'h83);
    measure(3, 18, 6, "R9", "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule